// File: doc/BRIEF.md
# Descriptor-Chained XOR Copy Engine

This block is one channel of a memory offload engine. Software leaves a linked list of descriptors in memory, loads the address of the first one into the channel's head-pointer register and pulses the start input. The channel then works through the list without further help. For each descriptor it reads the whole descriptor. For every 32-bit word of the transfer it reads the word at the same offset from each enabled source buffer and folds it into an accumulator with XOR. It writes the result once to the destination, then writes the descriptor's status word back with the engine-ownership flag cleared. It then follows the link word. A copy is the same walk with only source 0 read.

All memory traffic uses one request stream and one read-response stream, both valid/ready. A request (read or write) holds its valid, address, write flag and write data steady until ready is seen. The engine has at most one read outstanding and raises response-ready only while it waits for that read. The memory may stall either stream for any number of cycles. When the channel finds a null link it parks and keeps that last descriptor in its current-descriptor output. Software can then patch the link in memory and start the channel again at the appended work. Single-cycle event pulses feed an external interrupt-cause register.

Top module: `xor_chain_engine`

## Requirements
- R1: After reset the channel state is 0 (idle), no request is raised, the current-descriptor output is 0 and all three event outputs are low.
- R2: A start pulse while the channel is not active is accepted only if the mode input is 1 (XOR) or 2 (copy). The channel then latches the mode and the swap input. It copies the head-pointer register into the current-descriptor output and shows state 1 (active). Any other mode value leaves the channel idle with no memory request. A start from state 2 (halted) is accepted like one from state 0.
- R3: A descriptor is 13 words fetched in ascending address order: +0x00 status (bit 31 = owned by engine), +0x04 command (bits 7:0 enable sources 0..7, bit 31 requests an end-of-descriptor event), +0x08 byte count, +0x0C destination, +0x10 next link, and +0x14 + 4*i the address of source i.
- R4: In XOR mode, each destination word k is the XOR of word k of every enabled source. The sources are read in ascending index order, and each word is written exactly once after its last source read. An empty source mask writes zero words. The number of words is the byte count divided by 4.
- R5: In copy mode only source 0 is read, whatever the source mask holds.
- R6: After the last data word the status word is written back at the descriptor address with bit 31 cleared and all other bits unchanged.
- R7: A non-zero link makes the channel fetch the next descriptor at that address without a new start pulse, and the current-descriptor output moves to it.
- R8: A zero link returns the channel to state 0 with the current-descriptor output still on the last descriptor. The end-of-chain and stopped outputs pulse high together for exactly one cycle.
- R9: The end-of-descriptor output pulses for one cycle after a descriptor's status write-back only when command bit 31 is set.
- R10: A byte count below MIN_BYTES causes no data access and no status write. The channel goes to state 2 (halted) with the stopped output pulsed and the end-of-chain output low, and the current-descriptor output stays on the offending descriptor.
- R11: With swap set at start, every fetched descriptor word is byte-reversed before use, and the status write-back is byte-reversed too. Source and destination data words are never reversed.
- R12: A raised request keeps its valid, address, write flag and data until accepted. Response-ready is raised only while one read is outstanding and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Operating mode: 1 XOR, 2 copy, latched at start |
| cfg_swap | input | 1 | Byte-reverse descriptor words, latched at start |
| head_wr_en | input | 1 | Load the head-pointer register |
| head_wr_data | input | ADDR_W | Value for the head-pointer register |
| start | input | 1 | Start pulse |
| cur_desc | output | ADDR_W | Address of the descriptor being or last handled |
| chan_state | output | 2 | 0 idle, 1 active, 2 halted on short count |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Engine waits for read data |
| mem_rsp_data | input | 32 | Read data |
| evt_eod | output | 1 | End-of-descriptor pulse |
| evt_eoc | output | 1 | End-of-chain pulse |
| evt_stop | output | 1 | Channel-stopped pulse |

## Verification
The hardest case to reach from the ports is the handover between descriptors: the status write of one descriptor, then the first fetch at its link, while the memory stalls the request and delays responses by varying amounts. A second hard case is a restart from the halted state. The bench builds whole chains in a memory model before each start. Request-ready and response latency come from an LFSR, so every handover falls under a different stall pattern. A short-count descriptor is followed by a rewritten, byte-swapped one at the same address and started again from the halted state.

// File: rtl/xeng_pkg.sv
`timescale 1ns/1ps
package xeng_pkg;
  localparam int WORD_W     = 32;
  // descriptor word offsets (in words)
  localparam int OFS_STATUS = 0;
  localparam int OFS_CMD    = 1;
  localparam int OFS_COUNT  = 2;
  localparam int OFS_DEST   = 3;
  localparam int OFS_NEXT   = 4;
  localparam int OFS_SRC0   = 5;
  localparam int OWN_BIT    = 31;
  localparam int EOD_BIT    = 31;

  localparam logic [2:0] MODE_XOR  = 3'd1;
  localparam logic [2:0] MODE_COPY = 3'd2;

  localparam logic [1:0] CH_IDLE   = 2'd0;
  localparam logic [1:0] CH_ACTIVE = 2'd1;
  localparam logic [1:0] CH_HALTED = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH_REQ,
    S_FETCH_RSP,
    S_CHECK,
    S_SRC_REQ,
    S_SRC_RSP,
    S_DST_WR,
    S_STAT_WR
  } seq_state_t;
endpackage

// File: rtl/xeng_byte_swap.sv
`timescale 1ns/1ps
module xeng_byte_swap #(
  parameter int W = 32
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;
  logic [W-1:0] rev;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign rev[8*b +: 8] = din[8*(NB-1-b) +: 8];
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/xeng_src_pick.sv
`timescale 1ns/1ps
// Finds the lowest enabled source whose index is at least 'from'.
module xeng_src_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic [IW:0]   from,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [N-1:0] elig;

  for (genvar i = 0; i < N; i++) begin : g_elig
    localparam logic [IW:0] POS = (IW+1)'(i);
    assign elig[i] = mask[i] && (POS >= from);
  end

  always_comb begin
    hit = |elig;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xeng_accum.sv
`timescale 1ns/1ps
module xeng_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         fold,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (clr)  acc <= '0;
    else if (fold) acc <= acc ^ din;
  end
endmodule

// File: rtl/xor_chain_engine.sv
`timescale 1ns/1ps
module xor_chain_engine
  import xeng_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_SRC   = 8,
  parameter int MIN_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_swap,
  input  logic              head_wr_en,
  input  logic [ADDR_W-1:0] head_wr_data,
  input  logic              start,
  output logic [ADDR_W-1:0] cur_desc,
  output logic [1:0]        chan_state,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  output logic              evt_eod,
  output logic              evt_eoc,
  output logic              evt_stop
);
  localparam int DESC_WORDS = OFS_SRC0 + NUM_SRC;
  localparam int FIDX_W     = $clog2(DESC_WORDS);
  localparam int SIDX_W     = $clog2(NUM_SRC);
  localparam int WIDX_W     = WORD_W - 2;
  localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(DESC_WORDS - 1);
  localparam logic [WORD_W-1:0] MIN_CNT   = WORD_W'(MIN_BYTES);

  seq_state_t          state_q;
  logic [ADDR_W-1:0]   cur_q, head_q;
  logic [2:0]          mode_q;
  logic                swap_q;
  logic [1:0]          chst_q;
  logic [FIDX_W-1:0]   fidx_q;
  logic [SIDX_W-1:0]   sidx_q;
  logic [WIDX_W-1:0]   widx_q;
  logic [WORD_W-1:0]   desc_q [DESC_WORDS];
  logic                eod_q, eoc_q, stop_q;

  // derived descriptor views
  logic [WORD_W-1:0]   fetched, stat_clr, stat_wb, acc;
  logic [WIDX_W-1:0]   nwords;
  logic [NUM_SRC-1:0]  src_mask;
  logic [FIDX_W-1:0]   src_slot;
  logic [ADDR_W-1:0]   woff, src_addr, dst_addr, next_addr;
  logic                mode_ok, short_cnt, next_zero, last_word;
  logic [SIDX_W:0]     pick_from;
  logic                pick_hit;
  logic [SIDX_W-1:0]   pick_idx;
  logic                acc_clr, acc_fold;

  xeng_byte_swap #(.W(WORD_W)) u_swap_in (
    .en(swap_q), .din(mem_rsp_data), .dout(fetched)
  );

  assign stat_clr = desc_q[OFS_STATUS] & ~(WORD_W'(1) << OWN_BIT);

  xeng_byte_swap #(.W(WORD_W)) u_swap_out (
    .en(swap_q), .din(stat_clr), .dout(stat_wb)
  );

  assign mode_ok   = (cfg_mode == MODE_XOR) || (cfg_mode == MODE_COPY);
  assign nwords    = desc_q[OFS_COUNT][WORD_W-1:2];
  assign short_cnt = desc_q[OFS_COUNT] < MIN_CNT;
  assign last_word = widx_q == (nwords - WIDX_W'(1));
  assign src_mask  = (mode_q == MODE_COPY) ? NUM_SRC'(1) : desc_q[OFS_CMD][NUM_SRC-1:0];
  assign src_slot  = FIDX_W'(OFS_SRC0) + FIDX_W'(sidx_q);
  assign woff      = ADDR_W'({widx_q, 2'b00});
  assign src_addr  = desc_q[src_slot][ADDR_W-1:0] + woff;
  assign dst_addr  = desc_q[OFS_DEST][ADDR_W-1:0] + woff;
  assign next_addr = desc_q[OFS_NEXT][ADDR_W-1:0];
  assign next_zero = next_addr == '0;

  // next source lookup: continue after current source, else restart at 0
  assign pick_from = (state_q == S_SRC_RSP) ? ({1'b0, sidx_q} + (SIDX_W+1)'(1)) : '0;

  xeng_src_pick #(.N(NUM_SRC), .IW(SIDX_W)) u_pick (
    .mask(src_mask), .from(pick_from), .hit(pick_hit), .idx(pick_idx)
  );

  assign acc_clr  = (state_q == S_CHECK) || (state_q == S_DST_WR && mem_req_ready);
  assign acc_fold = (state_q == S_SRC_RSP) && mem_rsp_valid;

  xeng_accum #(.W(WORD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .fold(acc_fold),
    .din(mem_rsp_data), .acc(acc)
  );

  // memory request stream
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    unique case (state_q)
      S_FETCH_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = cur_q + ADDR_W'({fidx_q, 2'b00});
      end
      S_SRC_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = src_addr;
      end
      S_DST_WR: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = dst_addr;
        mem_req_wdata = acc;
      end
      S_STAT_WR: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = cur_q;
        mem_req_wdata = stat_wb;
      end
      default: ;
    endcase
  end

  assign mem_rsp_ready = (state_q == S_FETCH_RSP) || (state_q == S_SRC_RSP);

  // chain sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      head_q  <= '0;
      mode_q  <= MODE_XOR;
      swap_q  <= 1'b0;
      chst_q  <= CH_IDLE;
      fidx_q  <= '0;
      sidx_q  <= '0;
      widx_q  <= '0;
      eod_q   <= 1'b0;
      eoc_q   <= 1'b0;
      stop_q  <= 1'b0;
      for (int k = 0; k < DESC_WORDS; k++) desc_q[k] <= '0;
    end else begin
      eod_q  <= 1'b0;
      eoc_q  <= 1'b0;
      stop_q <= 1'b0;
      if (head_wr_en) head_q <= head_wr_data;

      unique case (state_q)
        S_IDLE: begin
          if (start && mode_ok) begin
            cur_q   <= head_q;
            mode_q  <= cfg_mode;
            swap_q  <= cfg_swap;
            fidx_q  <= '0;
            chst_q  <= CH_ACTIVE;
            state_q <= S_FETCH_REQ;
          end
        end
        S_FETCH_REQ: if (mem_req_ready) state_q <= S_FETCH_RSP;
        S_FETCH_RSP: begin
          if (mem_rsp_valid) begin
            desc_q[fidx_q] <= fetched;
            if (fidx_q == FIDX_LAST) begin
              state_q <= S_CHECK;
            end else begin
              fidx_q  <= fidx_q + FIDX_W'(1);
              state_q <= S_FETCH_REQ;
            end
          end
        end
        S_CHECK: begin
          if (short_cnt) begin
            chst_q  <= CH_HALTED;
            stop_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            widx_q <= '0;
            if (pick_hit) begin
              sidx_q  <= pick_idx;
              state_q <= S_SRC_REQ;
            end else begin
              state_q <= S_DST_WR;
            end
          end
        end
        S_SRC_REQ: if (mem_req_ready) state_q <= S_SRC_RSP;
        S_SRC_RSP: begin
          if (mem_rsp_valid) begin
            if (pick_hit) begin
              sidx_q  <= pick_idx;
              state_q <= S_SRC_REQ;
            end else begin
              state_q <= S_DST_WR;
            end
          end
        end
        S_DST_WR: begin
          if (mem_req_ready) begin
            if (last_word) begin
              state_q <= S_STAT_WR;
            end else begin
              widx_q <= widx_q + WIDX_W'(1);
              if (pick_hit) begin
                sidx_q  <= pick_idx;
                state_q <= S_SRC_REQ;
              end else begin
                state_q <= S_DST_WR;
              end
            end
          end
        end
        S_STAT_WR: begin
          if (mem_req_ready) begin
            eod_q <= desc_q[OFS_CMD][EOD_BIT];
            if (next_zero) begin
              eoc_q   <= 1'b1;
              stop_q  <= 1'b1;
              chst_q  <= CH_IDLE;
              state_q <= S_IDLE;
            end else begin
              cur_q   <= next_addr;
              fidx_q  <= '0;
              state_q <= S_FETCH_REQ;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cur_desc   = cur_q;
  assign chan_state = chst_q;
  assign evt_eod    = eod_q;
  assign evt_eoc    = eoc_q;
  assign evt_stop   = stop_q;
endmodule

// File: rtl/xeng_checker.sv
`timescale 1ns/1ps
module xeng_checker
  import xeng_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              mem_rsp_ready,
  input logic [1:0]        chan_state,
  input logic [ADDR_W-1:0] cur_desc,
  input logic              evt_eod,
  input logic              evt_eoc,
  input logic              evt_stop
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  assert_rsp_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> (!mem_req_valid && chan_state == CH_ACTIVE));

  assert_req_only_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> chan_state == CH_ACTIVE);

  assert_tail_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_eoc |-> (evt_stop && chan_state == CH_IDLE));

  assert_parked_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state != CH_ACTIVE) |=> (chan_state == CH_ACTIVE || $stable(cur_desc)));

  assert_short_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == CH_HALTED && $past(chan_state) == CH_ACTIVE) |-> (evt_stop && !evt_eoc));

  assert_eod_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_eod |=> !evt_eod);
endmodule

bind xor_chain_engine xeng_checker #(.ADDR_W(ADDR_W)) u_xeng_checker (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_ready(mem_rsp_ready),
  .chan_state(chan_state), .cur_desc(cur_desc),
  .evt_eod(evt_eod), .evt_eoc(evt_eoc), .evt_stop(evt_stop)
);

// File: tb/xor_chain_engine_test.sv
`timescale 1ns/1ps
module xor_chain_engine_test;
  localparam int AW = 32;
  localparam int NS = 8;
  localparam int MINB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [2:0]  cfg_mode = 3'd1;
  logic        cfg_swap = 1'b0;
  logic        head_wr_en = 1'b0;
  logic [AW-1:0] head_wr_data = '0;
  logic        start = 1'b0;
  logic [AW-1:0] cur_desc;
  logic [1:0]  chan_state;
  logic        mem_req_valid, mem_req_write, mem_rsp_ready;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        req_rdy = 1'b0;
  logic        rsp_v = 1'b0;
  logic [31:0] rsp_d = '0;
  logic        evt_eod, evt_eoc, evt_stop;

  xor_chain_engine #(.ADDR_W(AW), .NUM_SRC(NS), .MIN_BYTES(MINB)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_swap(cfg_swap),
    .head_wr_en(head_wr_en), .head_wr_data(head_wr_data), .start(start),
    .cur_desc(cur_desc), .chan_state(chan_state),
    .mem_req_valid(mem_req_valid), .mem_req_ready(req_rdy),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(rsp_v),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(rsp_d),
    .evt_eod(evt_eod), .evt_eoc(evt_eoc), .evt_stop(evt_stop)
  );

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } txn_t;

  txn_t        expq[$];
  logic [31:0] mem [0:1023];
  int checks = 0, fails = 0;
  int n_eod = 0, n_eoc = 0, n_stop = 0, n_rd = 0, n_rsp = 0;
  bit rd_pend = 0, rsp_fired = 0;
  int rd_lat = 0;
  logic [31:0] rd_addr = '0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] bswap(logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic void push(bit wr, logic [31:0] a, logic [31:0] d, string t);
    txn_t e;
    e.wr = wr; e.addr = a; e.data = d; e.tag = t;
    expq.push_back(e);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model + scoreboard monitor, all on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (rsp_fired) begin rsp_v = 1'b0; rsp_fired = 0; n_rsp++; end
      if (rd_pend && !rsp_v) begin
        if (rd_lat == 0) begin
          rsp_v = 1'b1; rsp_d = mem[rd_addr[11:2]]; rd_pend = 0;
        end else rd_lat--;
      end
      if (rsp_v && mem_rsp_ready) rsp_fired = 1;
      req_rdy = lfsr[0] | lfsr[3];
      if (mem_req_valid && req_rdy) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R3 unexpected request actual=%0b/%h expected=none",
                   mem_req_write, mem_req_addr);
        end else begin
          txn_t e;
          e = expq.pop_front();
          if (e.wr != mem_req_write || e.addr !== mem_req_addr ||
              (e.wr && e.data !== mem_req_wdata)) begin
            fails++;
            $display("FAIL %s actual=%0b/%h/%h expected=%0b/%h/%h", e.tag,
                     mem_req_write, mem_req_addr, mem_req_wdata, e.wr, e.addr, e.data);
          end
        end
        if (mem_req_write) mem[mem_req_addr[11:2]] = mem_req_wdata;
        else begin rd_pend = 1; rd_lat = int'(lfsr[5:4]); rd_addr = mem_req_addr; n_rd++; end
      end
      if (evt_eod)  n_eod++;
      if (evt_eoc)  n_eoc++;
      if (evt_stop) n_stop++;
    end
  end

  // driver: places a descriptor in memory and queues the expected traffic
  task automatic build_desc(input logic [31:0] da, input logic [31:0] cmd,
                            input logic [31:0] cnt, input logic [31:0] dst,
                            input logic [31:0] nxt, input bit copy, input bit sw,
                            input bit with_data);
    logic [31:0] f [13];
    logic [31:0] a, acc, sa;
    logic [7:0]  mask;
    f[0] = 32'h8000_5A00; f[1] = cmd; f[2] = cnt; f[3] = dst; f[4] = nxt;
    for (int i = 0; i < 8; i++) f[5+i] = 32'h400 + 32'(i) * 32'h40;
    for (int k = 0; k < 13; k++) begin
      a = da + 32'(4 * k);
      mem[a[11:2]] = sw ? bswap(f[k]) : f[k];
      push(0, a, 32'h0, "R3 descriptor fetch");
    end
    if (!with_data) return;
    mask = copy ? 8'h01 : cmd[7:0];
    for (int w = 0; w < int'(cnt >> 2); w++) begin
      acc = '0;
      for (int i = 0; i < 8; i++) begin
        if (mask[i]) begin
          sa = f[5+i] + 32'(4 * w);
          push(0, sa, 32'h0, copy ? "R5 source read" : "R4 source read");
          acc = acc ^ mem[sa[11:2]];
        end
      end
      push(1, dst + 32'(4 * w), acc, copy ? "R5 copy write" : "R4 xor write");
    end
    push(1, da, sw ? bswap(32'h0000_5A00) : 32'h0000_5A00,
         sw ? "R11 swapped status" : "R6 status write-back");
  endtask

  task automatic run_chain(input logic [31:0] head, input logic [2:0] mode, input bit sw);
    int t;
    n_eod = 0; n_eoc = 0; n_stop = 0;
    cfg_mode = mode; cfg_swap = sw; head_wr_en = 1'b1; head_wr_data = head;
    @(negedge clk);
    head_wr_en = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (chan_state == 2'd1 && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = 32'hFFFF_FFFF;
    for (int i = 0; i < 8; i++)
      for (int w = 0; w < 16; w++)
        mem[(32'h400 >> 2) + i * 16 + w] = {8'(i + 1), 8'(w), 16'h3C5A ^ 16'(i * w * 77)};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", 32'(chan_state), 0);
    chk("R1 req_valid", 32'(mem_req_valid), 0);
    chk("R1 cur_desc", cur_desc, 0);
    chk("R1 events", {29'b0, evt_eod, evt_eoc, evt_stop}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 unsupported mode: activation ignored
    run_chain(32'h100, 3'd5, 0);
    repeat (20) @(negedge clk);
    chk("R2 bad mode state", 32'(chan_state), 0);
    chk("R2 bad mode reads", 32'(n_rd), 0);

    // R4/R6/R8/R9 single XOR descriptor, sources 0,2,5,7
    build_desc(32'h100, 32'h8000_00A5, 32'd16, 32'h800, 32'h0, 0, 0, 1);
    run_chain(32'h100, 3'd1, 0);
    chk("R4 all traffic seen", 32'(expq.size()), 0);
    chk("R9 eod count", 32'(n_eod), 1);
    chk("R8 eoc count", 32'(n_eoc), 1);
    chk("R8 stop count", 32'(n_stop), 1);
    chk("R8 cur_desc parked", cur_desc, 32'h100);
    chk("R8 idle", 32'(chan_state), 0);

    // R7 chain of two, first with empty mask and no event request
    build_desc(32'h180, 32'h0000_0000, 32'd20, 32'h880, 32'h200, 0, 0, 1);
    build_desc(32'h200, 32'h8000_0003, 32'd16, 32'h900, 32'h0, 0, 0, 1);
    run_chain(32'h180, 3'd1, 0);
    chk("R7 all traffic seen", 32'(expq.size()), 0);
    chk("R7 cur_desc last", cur_desc, 32'h200);
    chk("R9 eod only flagged", 32'(n_eod), 1);
    chk("R8 single eoc", 32'(n_eoc), 1);
    chk("R4 empty mask zero", mem[32'h880 >> 2], 32'h0);
    chk("R6 own cleared", mem[32'h180 >> 2], 32'h0000_5A00);

    // R5 copy mode ignores mask
    build_desc(32'h280, 32'h0000_00F0, 32'd16, 32'h980, 32'h0, 1, 0, 1);
    run_chain(32'h280, 3'd2, 0);
    chk("R5 all traffic seen", 32'(expq.size()), 0);
    chk("R5 copy data", mem[32'h98C >> 2], mem[32'h40C >> 2]);
    chk("R9 no eod", 32'(n_eod), 0);

    // R10 short byte count halts
    build_desc(32'h300, 32'h8000_0001, 32'd8, 32'hA00, 32'h0, 0, 0, 0);
    run_chain(32'h300, 3'd1, 0);
    chk("R10 traffic", 32'(expq.size()), 0);
    chk("R10 halted", 32'(chan_state), 2);
    chk("R10 stop", 32'(n_stop), 1);
    chk("R10 no eoc", 32'(n_eoc), 0);
    chk("R10 cur_desc", cur_desc, 32'h300);
    chk("R10 status untouched", mem[32'h300 >> 2], 32'h8000_5A00);

    // R11 swapped descriptor, restarted from halted (R2)
    build_desc(32'h300, 32'h8000_0011, 32'd16, 32'hA00, 32'h0, 0, 1, 1);
    run_chain(32'h300, 3'd1, 1);
    chk("R11 all traffic seen", 32'(expq.size()), 0);
    chk("R2 restart from halted", 32'(chan_state), 0);
    chk("R11 status swapped", mem[32'h300 >> 2], bswap(32'h0000_5A00));
    chk("R11 data unswapped", mem[32'hA00 >> 2], mem[32'h400 >> 2] ^ mem[32'h500 >> 2]);

    // R12 every read got exactly one response
    chk("R12 reads vs responses", 32'(n_rsp), 32'(n_rd));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule